// File: doc/BRIEF.md
# Multi-Size IO Translation Cache

This block is a small, fully associative cache of DMA address translations that sits beside an IO page-table walker. Each entry is tagged by the requesting source ID, the page level and the frame number of the guest page at that level. One store holds 4 KiB (level 1), 2 MiB (level 2) and 1 GiB (level 3) translations, and each entry keeps the page mask of its own level.

A lookup presents a source ID and an address. One clock later the block returns hit or miss, the page-aligned IO address, the translated base, the in-page offset mask and a two-bit permission code. The walker fills the cache after a completed walk by giving the source ID, domain ID, address, level, leaf address and read/write rights. Software-driven invalidations are applied through one operation port. An operation can drop every entry, every entry of one domain, or a page range within one domain. A page-range operation also removes a large page that covers the target address.

Top module: `multisize_xlat_cache`

## Requirements
- R1: After reset no entry is valid, respValid and respHit are 0, and the first lookup misses.
- R2: respValid is 1 in exactly the cycle after a cycle with lookupValid high. On a miss, respHit is 0 and respIova, respXlat, respAddrMask and respPerm are all zero.
- R3: The page of level L spans 2^(12+9(L-1)) bytes. A hit returns respIova = address AND page mask, respXlat = leaf AND page mask, and respAddrMask = the inverted page mask (0xFFF, 0x1FFFFF or 0x3FFFFFFF).
- R4: When entries at several levels match a lookup, the entry at the lowest level number wins, whatever slot each entry occupies.
- R5: A hit needs the source ID to match as well as the frame number and level.
- R6: respPerm bit 1 is the write right and bit 0 is the read right of the hit entry.
- R7: A fill whose source ID, level and level-masked frame number equal those of a valid entry overwrites that entry and takes no other slot.
- R8: A new key goes to the lowest-numbered free slot. When no slot is free, it evicts the slot named by a pointer that starts at 0 after reset and advances by one per eviction, wrapping after the last slot.
- R9: invOp = 1 (all) invalidates every entry in one cycle.
- R10: invOp = 2 (domain) invalidates exactly the entries whose domain ID equals invDid.
- R11: invOp = 3 (page) removes an entry of domain invDid when its frame number and the frame number of invAddr are equal with the low invOrder bits ignored.
- R12: invOp = 3 also removes an entry of domain invDid when invAddr, masked by that entry's own page mask, gives the entry's frame number. This covers a large page that contains the target.
- R13: When a fill and an invalidate arrive in the same cycle, the invalidate is applied first, so the new entry survives it.
- R14: A fill with fillLevel = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupSid | input | 16 | Requester source ID of the lookup |
| lookupAddr | input | 48 | IO address to translate |
| fillValid | input | 1 | Fill request this cycle |
| fillSid | input | 16 | Source ID of the new entry |
| fillDid | input | 16 | Domain ID of the new entry |
| fillAddr | input | 48 | IO address covered by the new entry |
| fillLevel | input | 2 | Page level 1..3 (0 ignored) |
| fillLeaf | input | 48 | Leaf (translated) address |
| fillRead | input | 1 | Read right |
| fillWrite | input | 1 | Write right |
| invOp | input | 2 | 0 none, 1 all, 2 domain, 3 page range |
| invDid | input | 16 | Domain for domain and page invalidation |
| invAddr | input | 48 | Target address for page invalidation |
| invOrder | input | 6 | Range order: low bits of frame number ignored |
| respValid | output | 1 | Response valid |
| respHit | output | 1 | Lookup hit |
| respIova | output | 48 | Page-aligned IO address |
| respXlat | output | 48 | Page-aligned translated address |
| respAddrMask | output | 48 | In-page offset mask |
| respPerm | output | 2 | {write, read} |

## Verification
The bench places a 1 GiB entry in a lower slot than a 4 KiB entry inside it. A design that resolved by slot instead of by level would return the large page. It fills three copies of one key plus fifteen other keys. A design that duplicated keys would overflow the store and lose one of the others. It runs a page invalidate whose range misses a 2 MiB entry while the target address lies inside that entry. A design that applied only the range test would keep the stale large page. Further cases are eviction order after the store fills, a fill that arrives with an invalidate of its own domain (a design that ordered these wrongly would drop the new entry), and domain filtering on each kind of invalidate.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  localparam int unsigned ADDR_W     = 48;
  localparam int unsigned SID_W      = 16;
  localparam int unsigned DID_W      = 16;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned LVL_BITS   = 9;
  localparam int unsigned NUM_LVL    = 3;
  localparam int unsigned LVL_W      = 2;
  localparam int unsigned ORDER_W    = 6;
  localparam int unsigned ENTRIES    = 16;
  localparam int unsigned IDX_W      = $clog2(ENTRIES);
  localparam int unsigned FRAME_W    = ADDR_W - PAGE_SHIFT;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [SID_W-1:0]   sid_t;
  typedef logic [DID_W-1:0]   did_t;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [IDX_W-1:0]   idx_t;

  typedef enum logic [1:0] {
    INV_NONE   = 2'd0,
    INV_ALL    = 2'd1,
    INV_DOMAIN = 2'd2,
    INV_PAGE   = 2'd3
  } inv_op_e;

  typedef struct packed {
    sid_t   sid;
    did_t   did;
    frame_t frame;
    lvl_t   lvl;
    addr_t  pageMask;
    addr_t  leaf;
    logic   rd;
    logic   wr;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    idx_t wrIdx;
    logic respLoad;
  } strobe_t;

  function automatic addr_t levelMask(input lvl_t l);
    int sh;
    sh = int'(PAGE_SHIFT) + (int'(l) - 1) * int'(LVL_BITS);
    return ~((addr_t'(1) << sh) - addr_t'(1));
  endfunction

  function automatic frame_t frameUnder(input addr_t a, input addr_t m);
    addr_t t;
    t = a & m;
    return t[ADDR_W-1:PAGE_SHIFT];
  endfunction

  function automatic logic levelLegal(input lvl_t l);
    return (l >= lvl_t'(1)) && (int'(l) <= int'(NUM_LVL));
  endfunction

endpackage

// File: rtl/xlat_cache_dpath.sv
module xlat_cache_dpath
  import xlat_cache_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  sid_t                 lookupSid,
  input  addr_t                lookupAddr,
  input  logic                 fillValid,
  input  sid_t                 fillSid,
  input  did_t                 fillDid,
  input  addr_t                fillAddr,
  input  lvl_t                 fillLevel,
  input  addr_t                fillLeaf,
  input  logic                 fillRead,
  input  logic                 fillWrite,
  input  inv_op_e              invOp,
  input  did_t                 invDid,
  input  addr_t                invAddr,
  input  logic [ORDER_W-1:0]   invOrder,
  output logic [ENTRIES-1:0]   keyMatchVec,
  output logic [ENTRIES-1:0]   freeVec,
  output logic                 respHit,
  output addr_t                respIova,
  output addr_t                respXlat,
  output addr_t                respAddrMask,
  output logic [1:0]           respPerm
);

  logic [ENTRIES-1:0] validQ;
  entry_t             entryQ [ENTRIES];
  logic [ENTRIES-1:0] killVec;
  logic [ENTRIES-1:0] validAfterInv;
  logic [ENTRIES-1:0] lookHitVec;
  frame_t             invFrame;
  frame_t             rangeMask;
  frame_t             fillFrame;
  addr_t              fillMask;
  entry_t             fillEntry;

  assign invFrame  = invAddr[ADDR_W-1:PAGE_SHIFT];
  assign rangeMask = ~((frame_t'(1) << invOrder) - frame_t'(1));
  assign fillMask  = levelMask(fillLevel);
  assign fillFrame = frameUnder(fillAddr, fillMask);

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    logic domHit;
    logic rangeHit;
    logic coverHit;
    assign domHit   = (entryQ[gi].did == invDid);
    assign rangeHit = ((entryQ[gi].frame & rangeMask) == (invFrame & rangeMask));
    assign coverHit = (entryQ[gi].frame == frameUnder(invAddr, entryQ[gi].pageMask));

    always_comb begin
      case (invOp)
        INV_ALL:    killVec[gi] = 1'b1;
        INV_DOMAIN: killVec[gi] = domHit;
        INV_PAGE:   killVec[gi] = domHit && (rangeHit || coverHit);
        default:    killVec[gi] = 1'b0;
      endcase
    end

    assign validAfterInv[gi] = validQ[gi] && !killVec[gi];
    assign freeVec[gi]       = !validAfterInv[gi];
    assign keyMatchVec[gi]   = fillValid && validAfterInv[gi] &&
                               (entryQ[gi].sid == fillSid) &&
                               (entryQ[gi].lvl == fillLevel) &&
                               (entryQ[gi].frame == fillFrame);
    assign lookHitVec[gi]    = validQ[gi] &&
                               (entryQ[gi].sid == lookupSid) &&
                               (entryQ[gi].frame == frameUnder(lookupAddr, entryQ[gi].pageMask));
  end

  always_comb begin
    fillEntry.sid      = fillSid;
    fillEntry.did      = fillDid;
    fillEntry.frame    = fillFrame;
    fillEntry.lvl      = fillLevel;
    fillEntry.pageMask = fillMask;
    fillEntry.leaf     = fillLeaf;
    fillEntry.rd       = fillRead;
    fillEntry.wr       = fillWrite;
  end

  // level-ordered probe: lowest level number wins
  logic found;
  idx_t selIdx;
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int l = 1; l <= int'(NUM_LVL); l++) begin
      for (int i = 0; i < int'(ENTRIES); i++) begin
        if (!found && lookHitVec[i] && (int'(entryQ[i].lvl) == l)) begin
          found  = 1'b1;
          selIdx = idx_t'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      validQ <= validAfterInv;
      if (strobe.wrEn) validQ[strobe.wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) entryQ[strobe.wrIdx] <= fillEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respHit      <= 1'b0;
      respIova     <= '0;
      respXlat     <= '0;
      respAddrMask <= '0;
      respPerm     <= '0;
    end else if (strobe.respLoad) begin
      respHit <= found;
      if (found) begin
        respIova     <= lookupAddr & entryQ[selIdx].pageMask;
        respXlat     <= entryQ[selIdx].leaf & entryQ[selIdx].pageMask;
        respAddrMask <= ~entryQ[selIdx].pageMask;
        respPerm     <= {entryQ[selIdx].wr, entryQ[selIdx].rd};
      end else begin
        respIova     <= '0;
        respXlat     <= '0;
        respAddrMask <= '0;
        respPerm     <= '0;
      end
    end
  end

  // R7
  fill_key_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> $onehot0(keyMatchVec));

  // R9
  global_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invOp == INV_ALL && !strobe.wrEn) |=> (validQ == '0));

  // R3
  resp_mask_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> ((respAddrMask == ~levelMask(lvl_t'(1))) ||
                 (respAddrMask == ~levelMask(lvl_t'(2))) ||
                 (respAddrMask == ~levelMask(lvl_t'(3)))));

  // R3
  resp_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> (((respXlat & respAddrMask) == '0) && ((respIova & respAddrMask) == '0)));

endmodule

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl
  import xlat_cache_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               fillValid,
  input  lvl_t               fillLevel,
  input  logic [ENTRIES-1:0] keyMatchVec,
  input  logic [ENTRIES-1:0] freeVec,
  output strobe_t            strobe,
  output logic               respValid
);

  idx_t rrPtr;
  idx_t matchIdx;
  idx_t freeIdx;
  logic matchAny;
  logic freeAny;
  logic fillOk;
  logic evict;

  assign matchAny = |keyMatchVec;
  assign freeAny  = |freeVec;
  assign fillOk   = fillValid && levelLegal(fillLevel);
  assign evict    = fillOk && !matchAny && !freeAny;

  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (keyMatchVec[i]) matchIdx = idx_t'(i);
      if (freeVec[i])     freeIdx  = idx_t'(i);
    end
  end

  always_comb begin
    strobe.wrEn     = fillOk;
    strobe.respLoad = lookupValid;
    if (matchAny)     strobe.wrIdx = matchIdx;
    else if (freeAny) strobe.wrIdx = freeIdx;
    else              strobe.wrIdx = rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr     <= '0;
      respValid <= 1'b0;
    end else begin
      respValid <= lookupValid;
      if (evict) rrPtr <= (rrPtr == idx_t'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // R14
  fill_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (fillValid && fillLevel != '0));

  // R7
  fill_replace_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && matchAny) |-> keyMatchVec[strobe.wrIdx]);

  // R8
  fill_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !matchAny && freeAny) |-> freeVec[strobe.wrIdx]);

endmodule

// File: rtl/multisize_xlat_cache.sv
module multisize_xlat_cache
  import xlat_cache_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [SID_W-1:0]    lookupSid,
  input  logic [ADDR_W-1:0]   lookupAddr,
  input  logic                fillValid,
  input  logic [SID_W-1:0]    fillSid,
  input  logic [DID_W-1:0]    fillDid,
  input  logic [ADDR_W-1:0]   fillAddr,
  input  logic [LVL_W-1:0]    fillLevel,
  input  logic [ADDR_W-1:0]   fillLeaf,
  input  logic                fillRead,
  input  logic                fillWrite,
  input  logic [1:0]          invOp,
  input  logic [DID_W-1:0]    invDid,
  input  logic [ADDR_W-1:0]   invAddr,
  input  logic [ORDER_W-1:0]  invOrder,
  output logic                respValid,
  output logic                respHit,
  output logic [ADDR_W-1:0]   respIova,
  output logic [ADDR_W-1:0]   respXlat,
  output logic [ADDR_W-1:0]   respAddrMask,
  output logic [1:0]          respPerm
);

  strobe_t            strobe;
  logic [ENTRIES-1:0] keyMatchVec;
  logic [ENTRIES-1:0] freeVec;
  inv_op_e            invOpE;

  assign invOpE = inv_op_e'(invOp);

  xlat_cache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .fillValid   (fillValid),
    .fillLevel   (fillLevel),
    .keyMatchVec (keyMatchVec),
    .freeVec     (freeVec),
    .strobe      (strobe),
    .respValid   (respValid)
  );

  xlat_cache_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lookupSid    (lookupSid),
    .lookupAddr   (lookupAddr),
    .fillValid    (fillValid),
    .fillSid      (fillSid),
    .fillDid      (fillDid),
    .fillAddr     (fillAddr),
    .fillLevel    (fillLevel),
    .fillLeaf     (fillLeaf),
    .fillRead     (fillRead),
    .fillWrite    (fillWrite),
    .invOp        (invOpE),
    .invDid       (invDid),
    .invAddr      (invAddr),
    .invOrder     (invOrder),
    .keyMatchVec  (keyMatchVec),
    .freeVec      (freeVec),
    .respHit      (respHit),
    .respIova     (respIova),
    .respXlat     (respXlat),
    .respAddrMask (respAddrMask),
    .respPerm     (respPerm)
  );

endmodule

// File: tb/multisize_xlat_cache_tb.sv
module multisize_xlat_cache_tb;
  import xlat_cache_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  sid_t lookupSid = '0;
  addr_t lookupAddr = '0;
  logic fillValid = 1'b0;
  sid_t fillSid = '0;
  did_t fillDid = '0;
  addr_t fillAddr = '0;
  lvl_t fillLevel = '0;
  addr_t fillLeaf = '0;
  logic fillRead = 1'b0;
  logic fillWrite = 1'b0;
  logic [1:0] invOp = 2'd0;
  did_t invDid = '0;
  addr_t invAddr = '0;
  logic [ORDER_W-1:0] invOrder = '0;
  logic respValid, respHit;
  addr_t respIova, respXlat, respAddrMask;
  logic [1:0] respPerm;

  int vecCount = 0;
  int errCount = 0;

  logic gotValid, gotHit;
  addr_t gotIova, gotXlat, gotMask;
  logic [1:0] gotPerm;

  localparam addr_t M4K = 48'h0000_0000_0FFF;
  localparam addr_t M2M = 48'h0000_001F_FFFF;
  localparam addr_t M1G = 48'h0000_3FFF_FFFF;

  always #5 clk = ~clk;

  multisize_xlat_cache u_dut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupSid(lookupSid), .lookupAddr(lookupAddr),
    .fillValid(fillValid), .fillSid(fillSid), .fillDid(fillDid), .fillAddr(fillAddr),
    .fillLevel(fillLevel), .fillLeaf(fillLeaf), .fillRead(fillRead), .fillWrite(fillWrite),
    .invOp(invOp), .invDid(invDid), .invAddr(invAddr), .invOrder(invOrder),
    .respValid(respValid), .respHit(respHit), .respIova(respIova), .respXlat(respXlat),
    .respAddrMask(respAddrMask), .respPerm(respPerm)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setFill(input sid_t s, input did_t d, input addr_t a, input lvl_t l,
                         input addr_t leaf, input logic r, input logic w);
    fillValid = 1'b1; fillSid = s; fillDid = d; fillAddr = a;
    fillLevel = l; fillLeaf = leaf; fillRead = r; fillWrite = w;
  endtask

  task automatic doFill(input sid_t s, input did_t d, input addr_t a, input lvl_t l,
                        input addr_t leaf, input logic r, input logic w);
    @(negedge clk);
    setFill(s, d, a, l, leaf, r, w);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doInv(input logic [1:0] op, input did_t d, input addr_t a, input int ord);
    @(negedge clk);
    invOp = op; invDid = d; invAddr = a; invOrder = ORDER_W'(ord);
    @(negedge clk);
    invOp = 2'd0;
  endtask

  task automatic doFillInv(input sid_t s, input did_t d, input addr_t a,
                           input logic [1:0] op, input did_t invD);
    @(negedge clk);
    setFill(s, d, a, 2'd1, 48'h0000_00AB_C000, 1'b1, 1'b1);
    invOp = op; invDid = invD; invAddr = '0; invOrder = '0;
    @(negedge clk);
    fillValid = 1'b0; invOp = 2'd0;
  endtask

  task automatic doLookup(input sid_t s, input addr_t a);
    @(negedge clk);
    lookupValid = 1'b1; lookupSid = s; lookupAddr = a;
    @(negedge clk);
    lookupValid = 1'b0;
    gotValid = respValid; gotHit = respHit; gotIova = respIova;
    gotXlat = respXlat; gotMask = respAddrMask; gotPerm = respPerm;
  endtask

  task automatic expectHit(input string tag, input sid_t s, input addr_t a, input addr_t eIova,
                           input addr_t eXlat, input addr_t eMask, input logic [1:0] ePerm);
    doLookup(s, a);
    check({tag, " valid"}, 64'(gotValid), 64'd1);
    check({tag, " hit"}, 64'(gotHit), 64'd1);
    check({tag, " iova"}, 64'(gotIova), 64'(eIova));
    check({tag, " xlat"}, 64'(gotXlat), 64'(eXlat));
    check({tag, " mask"}, 64'(gotMask), 64'(eMask));
    check({tag, " perm"}, 64'(gotPerm), 64'(ePerm));
  endtask

  task automatic expectMiss(input string tag, input sid_t s, input addr_t a);
    doLookup(s, a);
    check({tag, " valid"}, 64'(gotValid), 64'd1);
    check({tag, " hit"}, 64'(gotHit), 64'd0);
    check({tag, " xlat"}, 64'(gotXlat), 64'd0);
    check({tag, " mask"}, 64'(gotMask), 64'd0);
    check({tag, " perm"}, 64'(gotPerm), 64'd0);
  endtask

  task automatic testReset();
    check("R1 respValid after reset", 64'(respValid), 64'd0);
    check("R1 respHit after reset", 64'(respHit), 64'd0);
    expectMiss("R1 first lookup", 16'h0001, 48'h0000_0000_1000);
    @(negedge clk);
    check("R2 respValid drops", 64'(respValid), 64'd0);
  endtask

  task automatic testRoundRobin();
    for (int i = 0; i < 16; i++)
      doFill(sid_t'(16'h100 + i), 16'd1, addr_t'(i) << 12, 2'd1, 48'h5000_0000 + (addr_t'(i) << 12), 1'b1, 1'b1);
    doFill(16'h110, 16'd1, 48'h0001_0000, 2'd1, 48'h6000_0000, 1'b1, 1'b1);
    expectMiss("R8 first victim slot0", 16'h100, 48'h0);
    expectHit("R8 slot1 kept", 16'h101, 48'h1004, 48'h1000, 48'h5000_1000, M4K, 2'd3);
    expectHit("R8 new key", 16'h110, 48'h0001_0008, 48'h0001_0000, 48'h6000_0000, M4K, 2'd3);
    doFill(16'h111, 16'd1, 48'h0001_1000, 2'd1, 48'h6000_1000, 1'b1, 1'b1);
    expectMiss("R8 second victim slot1", 16'h101, 48'h1000);
    expectHit("R8 slot2 kept", 16'h102, 48'h2000, 48'h2000, 48'h5000_2000, M4K, 2'd3);
  endtask

  task automatic testLevels();
    doInv(2'd1, '0, '0, 0);
    doFill(16'h1, 16'd2, 48'h0000_4000_0000, 2'd3, 48'h0080_0000_0000, 1'b1, 1'b0);
    doFill(16'h1, 16'd2, 48'h0000_4000_2000, 2'd1, 48'h0012_3456_7ABC, 1'b1, 1'b1);
    doFill(16'h2, 16'd2, 48'h0000_0060_0000, 2'd2, 48'h000A_0020_0000, 1'b0, 1'b1);
    expectHit("R4 lowest level wins", 16'h1, 48'h0000_4000_2ABC,
              48'h0000_4000_2000, 48'h0012_3456_7000, M4K, 2'd3);
    expectHit("R3 one GiB page", 16'h1, 48'h0000_4000_5ABC,
              48'h0000_4000_0000, 48'h0080_0000_0000, M1G, 2'd1);
    expectHit("R3 two MiB page", 16'h2, 48'h0000_0065_4321,
              48'h0000_0060_0000, 48'h000A_0020_0000, M2M, 2'd2);
  endtask

  task automatic testSidAndPerm();
    doFill(16'h700, 16'd3, 48'h9000, 2'd1, 48'h0077_0000, 1'b1, 1'b1);
    expectMiss("R5 other sid", 16'h701, 48'h9000);
    expectHit("R5 own sid", 16'h700, 48'h9123, 48'h9000, 48'h0077_0000, M4K, 2'd3);
    doFill(16'h800, 16'd3, 48'hA000, 2'd1, 48'h0088_0000, 1'b0, 1'b0);
    expectHit("R6 no rights", 16'h800, 48'hA000, 48'hA000, 48'h0088_0000, M4K, 2'd0);
  endtask

  task automatic testReplace();
    doInv(2'd1, '0, '0, 0);
    doFill(16'h200, 16'd1, 48'h7000, 2'd1, 48'h1000, 1'b1, 1'b1);
    doFill(16'h200, 16'd1, 48'h7abc, 2'd1, 48'h2000, 1'b1, 1'b1);
    doFill(16'h200, 16'd1, 48'h7000, 2'd1, 48'h3000, 1'b1, 1'b0);
    for (int i = 0; i < 15; i++)
      doFill(sid_t'(16'h300 + i), 16'd1, 48'h7000, 2'd1, 48'h4000, 1'b1, 1'b1);
    expectHit("R7 replaced entry", 16'h200, 48'h7010, 48'h7000, 48'h3000, M4K, 2'd1);
    for (int i = 0; i < 15; i++)
      expectHit("R7 neighbour kept", sid_t'(16'h300 + i), 48'h7000, 48'h7000, 48'h4000, M4K, 2'd3);
  endtask

  task automatic testGlobalDomain();
    doInv(2'd1, '0, '0, 0);
    expectMiss("R9 global clears", 16'h300, 48'h7000);
    doFill(16'h400, 16'd3, 48'h1000, 2'd1, 48'h0011_0000, 1'b1, 1'b1);
    doFill(16'h401, 16'd4, 48'h2000, 2'd1, 48'h0022_0000, 1'b1, 1'b1);
    doInv(2'd2, 16'd3, '0, 0);
    expectMiss("R10 domain removed", 16'h400, 48'h1000);
    expectHit("R10 other domain kept", 16'h401, 48'h2000, 48'h2000, 48'h0022_0000, M4K, 2'd3);
  endtask

  task automatic testPageRange();
    doInv(2'd1, '0, '0, 0);
    doFill(16'hA00, 16'd7, 48'h1000_0000, 2'd1, 48'h0001_0000, 1'b1, 1'b1);
    doFill(16'hA00, 16'd7, 48'h1000_3000, 2'd1, 48'h0002_0000, 1'b1, 1'b1);
    doFill(16'hA00, 16'd7, 48'h1000_8000, 2'd1, 48'h0003_0000, 1'b1, 1'b1);
    doFill(16'hA01, 16'd8, 48'h1000_1000, 2'd1, 48'h0004_0000, 1'b1, 1'b1);
    doInv(2'd3, 16'd7, 48'h1000_0000, 3);
    expectMiss("R11 range base", 16'hA00, 48'h1000_0000);
    expectMiss("R11 range inside", 16'hA00, 48'h1000_3000);
    expectHit("R11 outside range", 16'hA00, 48'h1000_8000, 48'h1000_8000, 48'h0003_0000, M4K, 2'd3);
    expectHit("R11 other domain", 16'hA01, 48'h1000_1000, 48'h1000_1000, 48'h0004_0000, M4K, 2'd3);
  endtask

  task automatic testCover();
    doInv(2'd1, '0, '0, 0);
    doFill(16'h900, 16'd5, 48'h0040_0000, 2'd2, 48'h0B00_0000, 1'b1, 1'b1);
    doFill(16'h901, 16'd5, 48'h0040_5000, 2'd1, 48'h0C00_0000, 1'b1, 1'b1);
    doInv(2'd3, 16'd6, 48'h0040_3000, 0);
    expectHit("R12 wrong domain keeps large page", 16'h900, 48'h0040_1234,
              48'h0040_0000, 48'h0B00_0000, M2M, 2'd3);
    doInv(2'd3, 16'd5, 48'h0040_3000, 0);
    expectMiss("R12 covering large page removed", 16'h900, 48'h0040_1234);
    expectHit("R12 small page outside kept", 16'h901, 48'h0040_5010,
              48'h0040_5000, 48'h0C00_0000, M4K, 2'd3);
  endtask

  task automatic testSameCycle();
    doInv(2'd1, '0, '0, 0);
    doFill(16'h500, 16'd9, 48'h3000, 2'd1, 48'h00DE_0000, 1'b1, 1'b1);
    doFillInv(16'h501, 16'd9, 48'h4000, 2'd2, 16'd9);
    expectMiss("R13 old entry dropped", 16'h500, 48'h3000);
    expectHit("R13 fill after domain inv", 16'h501, 48'h4000, 48'h4000, 48'h00AB_C000, M4K, 2'd3);
    doFillInv(16'h502, 16'd9, 48'h5000, 2'd1, 16'd0);
    expectMiss("R13 global drops prior", 16'h501, 48'h4000);
    expectHit("R13 fill after global inv", 16'h502, 48'h5000, 48'h5000, 48'h00AB_C000, M4K, 2'd3);
  endtask

  task automatic testIllegalLevel();
    doFill(16'h600, 16'd1, 48'h6000, 2'd0, 48'h00EE_0000, 1'b1, 1'b1);
    expectMiss("R14 level zero ignored", 16'h600, 48'h6000);
  endtask

  initial begin
    #2_000_000;
    errCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRoundRobin();
    testLevels();
    testSidAndPerm();
    testReplace();
    testGlobalDomain();
    testPageRange();
    testCover();
    testSameCycle();
    testIllegalLevel();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule